// File: doc/BRIEF.md
# SPI Master Word Engine (clock-phase-zero)

This block moves one word at a time over a four-wire serial link as the bus master. The host places a word on a write strobe. The engine then pulls the active-low select line down and drives the first data bit at once. It produces the serial clock by dividing the system clock, shifts the word out while it samples the returning line, and releases select after a programmable hold. Received bits gather in a private shift register. The finished word moves into a readable buffer only when the final bit has been captured, and a completion flag rises at that moment.

The clock idle level, the word length (8 or 16 bits) and the bit order are configuration inputs. Three programmable counts, in system-clock cycles, set the minimum spacing around each word: the delay from select falling to the first clock edge, the hold from the last clock edge to select rising, and the gap between words. A write that arrives while a word or its gap is still running is kept, and it starts once the gap ends. The configuration inputs must stay steady while `busy` is high.

Top module: `spi_xfer_master`

## Requirements
- R1: With `cfg_wide`=0 a word is 8 bits and produces exactly 16 `sck` edges. With `cfg_wide`=1 it is 16 bits and produces exactly 32 edges.
- R2: While `ss_n` is high, `sck` equals `cfg_cpol`. During a word, consecutive `sck` edges are exactly `cfg_half` system cycles apart, with 0 treated as 1. This gives an even divisor with 50% duty.
- R3: Counting `sck` edges from 1, `miso` is captured on odd edges and `mosi` changes only on even edges below the last one. The first bit is already on `mosi` in the cycle in which `ss_n` falls.
- R4: With `cfg_lsb_first`=0 the bit at index n-1 is sent first and the first received bit lands at index n-1. With `cfg_lsb_first`=1 bit 0 goes first on both lines. An 8-bit word occupies `rx_word[7:0]` with the upper bits zero, and `tx_word[15:8]` is not sent.
- R5: `rx_word` keeps its previous value until the cycle of edge 2n-1, the last capture. At that edge it takes the complete received word in one step. Reading does not alter it.
- R6: `rx_done` rises in the cycle of edge 2n-1. It clears on the cycle after `rx_rd` is high. When a read and a completion fall in the same cycle, the completion wins.
- R7: `ss_n` is low for exactly `cfg_lead` cycles (0 treated as 1) before the first `sck` edge, and no edge coincides with its fall.
- R8: After edge 2n, `ss_n` stays low for exactly max(`cfg_trail`, `cfg_half`) cycles, with each value treated as at least 1.
- R9: When a start is pending, `ss_n` stays high between two words for exactly the larger of `cfg_idle` and 1, plus one cycle.
- R10: `busy` is high from the cycle after `tx_wr` until the engine is idle with nothing pending. A write during a word is held until the gap ends, and the most recent write is the word that is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_wide | input | 1 | 0: 8-bit word, 1: 16-bit word |
| cfg_half | input | CNT_W | Half clock period in system cycles |
| cfg_lead | input | CNT_W | Select-to-first-edge cycles |
| cfg_trail | input | CNT_W | Last-edge-to-deselect cycles |
| cfg_idle | input | CNT_W | Minimum gap between words |
| tx_wr | input | 1 | Write strobe: queue `tx_word` and start |
| tx_word | input | WORD_W | Word to transmit |
| rx_rd | input | 1 | Read strobe, clears `rx_done` |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| rx_word | output | WORD_W | Received word buffer |
| rx_done | output | 1 | Word complete flag |
| busy | output | 1 | Word, gap or pending start active |

## Verification
Two events can land on the same clock edge. One is the completion that sets `rx_done` at the last capture edge. The other is a host read that clears it. The bench holds `rx_rd` high across a whole word so that the two coincide. It then requires the flag to be high in the sample just after edge 2n-1 and low one cycle later. A second overlap is a queued write arriving mid-word while an earlier write is still pending. The word captured by the bench's slave model must be the later one, and the select-high gap must match R9.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_TRAIL = 3'd3,
    ST_GAP   = 3'd4
  } xfer_state_e;
endpackage

// File: rtl/spi_xfer_timer.sv
// Down counter for phase lengths; a load value of zero counts as one cycle.
module spi_xfer_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             count_en,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (load_val == '0) ? ONE : load_val;
    end else if (count_en && (cnt_q > ONE)) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ONE;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q <= ONE);
endmodule

// File: rtl/spi_xfer_shift.sv
// Transmit and receive shift registers plus the double-buffered receive word.
module spi_xfer_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              wide,
  input  logic              lsb_first,
  input  logic              sample,
  input  logic              advance,
  input  logic              finish,
  input  logic              miso,
  input  logic              rd,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word,
  output logic              done
);
  localparam int NARROW_W = WORD_W / 2;

  logic [WORD_W-1:0] tx_q, tx_d, rx_q, rx_d, rx_nx, buf_q, buf_d;
  logic              done_q, done_d;

  // Receive shift value including the bit on miso this cycle
  always_comb begin
    rx_nx = '0;
    if (wide) begin
      rx_nx = lsb_first ? {miso, rx_q[WORD_W-1:1]} : {rx_q[WORD_W-2:0], miso};
    end else if (lsb_first) begin
      rx_nx[NARROW_W-1:0] = {miso, rx_q[NARROW_W-1:1]};
    end else begin
      rx_nx[NARROW_W-1:0] = {rx_q[NARROW_W-2:0], miso};
    end
  end

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    buf_d  = buf_q;
    done_d = done_q;
    if (load) begin
      tx_d = load_word;
      rx_d = '0;
    end else begin
      if (advance) tx_d = lsb_first ? (tx_q >> 1) : (tx_q << 1);
      if (sample)  rx_d = rx_nx;
    end
    if (rd)     done_d = 1'b0;
    if (finish) begin
      buf_d  = rx_nx;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      buf_q  <= '0;
      done_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      buf_q  <= buf_d;
      done_q <= done_d;
    end
  end

  assign mosi    = lsb_first ? tx_q[0] : (wide ? tx_q[WORD_W-1] : tx_q[NARROW_W-1]);
  assign rx_word = buf_q;
  assign done    = done_q;
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic [CNT_W-1:0]  cfg_half,
  input  logic [CNT_W-1:0]  cfg_lead,
  input  logic [CNT_W-1:0]  cfg_trail,
  input  logic [CNT_W-1:0]  cfg_idle,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              rx_rd,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_done,
  output logic              busy
);
  localparam int EDGE_W = $clog2(2 * WORD_W + 1);
  localparam logic [EDGE_W-1:0] EDGES_WIDE   = EDGE_W'(2 * WORD_W);
  localparam logic [EDGE_W-1:0] EDGES_NARROW = EDGE_W'(WORD_W);

  xfer_state_e       state_q, state_d;
  logic [EDGE_W-1:0] edge_q, edge_d, edge_nx, edge_total;
  logic              sck_q, sck_d, ss_q, ss_d, pend_q, pend_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              ph_load, ph_en, ph_last, hp_en, hp_last;
  logic [CNT_W-1:0]  ph_val, trail_len;
  logic              start, edge_ev, odd_edge, even_mid, last_sample, final_edge;

  assign edge_total  = cfg_wide ? EDGES_WIDE : EDGES_NARROW;
  assign trail_len   = (cfg_trail > cfg_half) ? cfg_trail : cfg_half;
  assign start       = (state_q == ST_IDLE) && pend_q;
  assign edge_ev     = ((state_q == ST_LEAD) && ph_last) || ((state_q == ST_SHIFT) && hp_last);
  assign edge_nx     = edge_q + 1'b1;
  assign odd_edge    = edge_ev && edge_nx[0];
  assign even_mid    = edge_ev && !edge_nx[0] && (edge_nx != edge_total);
  assign last_sample = edge_ev && (edge_nx == (edge_total - 1'b1));
  assign final_edge  = edge_ev && (edge_nx == edge_total);

  // Phase sequencing and phase-timer loads
  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = cfg_lead;
    case (state_q)
      ST_IDLE:  if (pend_q) begin
                  state_d = ST_LEAD;
                  ph_load = 1'b1;
                end
      ST_LEAD:  if (ph_last) state_d = ST_SHIFT;
      ST_SHIFT: if (final_edge) begin
                  state_d = ST_TRAIL;
                  ph_load = 1'b1;
                  ph_val  = trail_len;
                end
      ST_TRAIL: if (ph_last) begin
                  state_d = ST_GAP;
                  ph_load = 1'b1;
                  ph_val  = cfg_idle;
                end
      ST_GAP:   if (ph_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign ph_en = (state_q == ST_LEAD) || (state_q == ST_TRAIL) || (state_q == ST_GAP);
  assign hp_en = (state_q == ST_SHIFT);

  always_comb begin
    edge_d = start ? '0 : (edge_ev ? edge_nx : edge_q);
    sck_d  = start ? cfg_cpol : (edge_ev ? ~sck_q : sck_q);
    ss_d   = (state_d == ST_IDLE) || (state_d == ST_GAP);
    pend_d = tx_wr ? 1'b1 : (start ? 1'b0 : pend_q);
    hold_d = tx_wr ? tx_word : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      sck_q   <= 1'b0;
      ss_q    <= 1'b1;
      pend_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      sck_q   <= sck_d;
      ss_q    <= ss_d;
      pend_q  <= pend_d;
      hold_q  <= hold_d;
    end
  end

  spi_xfer_timer #(.CNT_W(CNT_W)) i_phase_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .count_en (ph_en),
    .last     (ph_last)
  );

  spi_xfer_timer #(.CNT_W(CNT_W)) i_half_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (edge_ev),
    .load_val (cfg_half),
    .count_en (hp_en),
    .last     (hp_last)
  );

  spi_xfer_shift #(.WORD_W(WORD_W)) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_word (hold_q),
    .wide      (cfg_wide),
    .lsb_first (cfg_lsb_first),
    .sample    (odd_edge),
    .advance   (even_mid),
    .finish    (last_sample),
    .miso      (miso),
    .rd        (rx_rd),
    .mosi      (mosi),
    .rx_word   (rx_word),
    .done      (rx_done)
  );

  assign sck  = (state_q == ST_IDLE) ? cfg_cpol : sck_q;
  assign ss_n = ss_q;
  assign busy = (state_q != ST_IDLE) || pend_q;
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_cpol,
  input logic              tx_wr,
  input logic              rx_rd,
  input logic              sck,
  input logic              ss_n,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_done,
  input logic              busy
);
  // R2: idle clock level while deselected
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> (sck == cfg_cpol));

  // R3: clock edges only inside an asserted select
  p_sck_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sck) && $stable(cfg_cpol)) |-> (!ss_n && !$past(ss_n)));

  // R7: no clock edge at the select fall
  p_no_edge_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $stable(sck));

  // R5: receive buffer only changes with completion inside a word
  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> (rx_done && !ss_n));

  // R6: completion only inside a word
  p_done_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> !ss_n);

  // R6: a read outside a word clears the flag
  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_done && ss_n) |=> !rx_done);

  // R10: a write makes the engine busy
  p_busy_after_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> busy);
endmodule

bind spi_xfer_master spi_xfer_master_chk #(.WORD_W(WORD_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_cpol (cfg_cpol),
  .tx_wr    (tx_wr),
  .rx_rd    (rx_rd),
  .sck      (sck),
  .ss_n     (ss_n),
  .rx_word  (rx_word),
  .rx_done  (rx_done),
  .busy     (busy)
);

// File: tb/test_spi_xfer_master.sv
module test_spi_xfer_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_cpol, cfg_lsb_first, cfg_wide;
  logic [7:0]  cfg_half, cfg_lead, cfg_trail, cfg_idle;
  logic        tx_wr, rx_rd, miso;
  logic [15:0] tx_word;
  logic        sck, mosi, ss_n, rx_done, busy;
  logic [15:0] rx_word;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  spi_xfer_master i_spi_xfer_master (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_lsb_first(cfg_lsb_first),
    .cfg_wide(cfg_wide), .cfg_half(cfg_half), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail),
    .cfg_idle(cfg_idle), .tx_wr(tx_wr), .tx_word(tx_word), .rx_rd(rx_rd), .miso(miso),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .rx_word(rx_word), .rx_done(rx_done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int at_least1(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic logic bit_of(input logic [15:0] w, input int idx, input logic lsb, input logic wide);
    int n = wide ? 16 : 8;
    return lsb ? w[idx] : w[n-1-idx];
  endfunction

  function automatic logic [15:0] masked(input logic [15:0] w, input logic wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  task automatic set_cfg(input logic cp, lsb, wd, input logic [7:0] h, l, t, i);
    @(negedge clk);
    cfg_cpol = cp; cfg_lsb_first = lsb; cfg_wide = wd;
    cfg_half = h; cfg_lead = l; cfg_trail = t; cfg_idle = i;
  endtask

  task automatic pulse_wr(input logic [15:0] w);
    @(negedge clk);
    tx_wr = 1'b1; tx_word = w;
    @(negedge clk);
    tx_wr = 1'b0;
    chk(busy == 1'b1, "R10", "busy after write", busy, 1);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(!busy, "R10", "busy drops after word", busy, 0);
  endtask

  // Observes one word at the pins and plays the slave side
  task automatic run_word(input logic [15:0] mtx, input logic [15:0] stx, input bit rd_hold, input int exp_gap);
    int n  = cfg_wide ? 16 : 8;
    int hn = at_least1(cfg_half);
    int ln = at_least1(cfg_lead);
    int tn = (at_least1(cfg_trail) > hn) ? at_least1(cfg_trail) : hn;
    int hi = 0, t = 0, edges = 0, t_last = 0, t_set = -10, midx = 0, sidx = 0, bad_mosi = 0;
    logic [15:0] cap = '0, rx_before;
    logic prev_sck, prev_mosi;
    while (ss_n && hi < 2000) begin
      @(negedge clk);
      if (ss_n) hi++;
    end
    rx_before = rx_word;
    chk(mosi == bit_of(mtx, 0, cfg_lsb_first, cfg_wide), "R3", "first bit at select fall", mosi,
        bit_of(mtx, 0, cfg_lsb_first, cfg_wide));
    chk(sck == cfg_cpol, "R7", "no edge at select fall", sck, cfg_cpol);
    if (exp_gap >= 0) chk(hi == exp_gap, "R9", "extra high cycles between words", hi, exp_gap);
    miso = bit_of(stx, 0, cfg_lsb_first, cfg_wide);
    prev_sck = sck; prev_mosi = mosi;
    while (!ss_n && t < 4000) begin
      @(negedge clk);
      t++;
      if (rd_hold && t == t_set + 1)
        chk(!rx_done, "R6", "read clears flag one cycle after set", rx_done, 0);
      if (sck !== prev_sck) begin
        edges++;
        if (edges == 1) chk(t == ln, "R7", "lead cycles", t, ln);
        else chk(t - t_last == hn, "R2", "half period", t - t_last, hn);
        t_last = t;
        if (edges % 2 == 1) begin
          cap[cfg_lsb_first ? midx : n-1-midx] = mosi;
          midx++;
        end else if (edges < 2*n) begin
          sidx++;
          miso = bit_of(stx, sidx, cfg_lsb_first, cfg_wide);
        end
        if (mosi !== prev_mosi && (edges % 2 == 1 || edges == 2*n)) bad_mosi++;
        if (edges == 2*n-2) chk(rx_word == rx_before, "R5", "buffer held before last capture", rx_word, rx_before);
        if (edges == 2*n-1) begin
          t_set = t;
          chk(rx_done == 1'b1, "R6", "flag at last capture", rx_done, 1);
          chk(rx_word == masked(stx, cfg_wide), "R4", "received word", rx_word, masked(stx, cfg_wide));
        end
      end else if (mosi !== prev_mosi) begin
        bad_mosi++;
      end
      prev_sck = sck; prev_mosi = mosi;
    end
    chk(t - t_last == tn, "R8", "trail cycles", t - t_last, tn);
    chk(edges == 2*n, "R1", "edge count", edges, 2*n);
    chk(cap == masked(mtx, cfg_wide), "R4", "word seen by slave", cap, masked(mtx, cfg_wide));
    chk(bad_mosi == 0, "R3", "mosi changes off even edges", bad_mosi, 0);
  endtask

  task automatic read_clear();
    logic [15:0] keep = rx_word;
    chk(rx_done == 1'b1, "R6", "flag holds until read", rx_done, 1);
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    chk(!rx_done, "R6", "flag cleared by read", rx_done, 0);
    chk(rx_word == keep, "R5", "read leaves buffer", rx_word, keep);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    rst_n = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; miso = 1'b0; tx_word = '0;
    cfg_cpol = 1'b0; cfg_lsb_first = 1'b0; cfg_wide = 1'b0;
    cfg_half = 8'd1; cfg_lead = 8'd1; cfg_trail = 8'd1; cfg_idle = 8'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ss_n == 1'b1, "R7", "reset select high", ss_n, 1);
    chk(sck == 1'b0, "R2", "reset clock idle", sck, 0);
    chk(rx_done == 1'b0, "R6", "reset flag", rx_done, 0);
    chk(busy == 1'b0, "R10", "reset busy", busy, 0);
    chk(rx_word == 16'h0, "R5", "reset buffer", rx_word, 0);

    // Directed: 8-bit, MSB first, idle low, trail set by half period
    set_cfg(1'b0, 1'b0, 1'b0, 8'd2, 8'd3, 8'd1, 8'd2);
    pulse_wr(16'hFFA5);
    run_word(16'hFFA5, 16'h003C, 1'b0, -1);
    read_clear();
    wait_idle();

    // Directed: 16-bit, LSB first, idle high, zero counts treated as one
    set_cfg(1'b1, 1'b1, 1'b1, 8'd1, 8'd0, 8'd5, 8'd0);
    pulse_wr(16'h8131);
    run_word(16'h8131, 16'hC3E7, 1'b0, -1);
    read_clear();
    wait_idle();

    // Directed: read held across the completion edge (R6 collision)
    set_cfg(1'b1, 1'b1, 1'b0, 8'd3, 8'd2, 8'd0, 8'd1);
    rx_rd = 1'b1;
    pulse_wr(16'h005A);
    run_word(16'h005A, 16'h0096, 1'b1, -1);
    rx_rd = 1'b0;
    wait_idle();

    // Directed: writes during a word are held, the latest wins (R10, R9)
    set_cfg(1'b0, 1'b0, 1'b1, 8'd1, 8'd1, 8'd1, 8'd3);
    pulse_wr(16'h1234);
    fork
      run_word(16'h1234, 16'hBEEF, 1'b0, -1);
      begin
        repeat (6) @(negedge clk);
        pulse_wr(16'hAAAA);
        pulse_wr(16'h0F0F);
      end
    join
    run_word(16'h0F0F, 16'h7001, 1'b0, 3);
    read_clear();
    wait_idle();

    // Random words across all modes
    for (int k = 0; k < 40; k++) begin
      logic [15:0] m = 16'($urandom);
      logic [15:0] s = 16'($urandom);
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom_range(0, 3)),
              8'($urandom_range(0, 4)), 8'($urandom_range(0, 5)), 8'($urandom_range(0, 3)));
      pulse_wr(m);
      run_word(m, s, 1'b0, -1);
      read_clear();
      wait_idle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule